// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block is the output stage of an event timer. Each timer channel reports a fire event when its comparator matches and a clear event when software acknowledges it. The router turns those events into activity on a bank of interrupt output lines. Each channel has a status bit. A channel can signal in three ways: it can hold its line high (level), it can give one pulse (edge), or it can bypass the pins and issue a message request that carries that channel's stored address and data words.

Each channel picks its output line with its own route field. A global legacy mode overrides that choice: channel 0 takes line 0 and channel 1 takes line 8. When legacy mode is off, the system tick timer input is forwarded onto line 0 and the real-time clock input onto line 8. Both inputs go through a capture register first. The captured real-time clock level is kept in both modes so that line 8 can be restored when legacy mode is turned off. The block also drives an enable output for the tick timer, which is low while legacy mode holds lines 0 and 8.

Top module: `irq_router`

## Requirements
- R1: When `legacyMode` is 1, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold. Every other channel, and channels 0 and 1 when `legacyMode` is 0, drives the line whose index equals its 4-bit route field (`chRoute[4*c+3:4*c]`).
- R2: A fire on an armed, level-type channel (`chLevel`=1, message route off) sets its status bit. The channel's line then stays high until a clear event, or a fire that clears, drops it.
- R3: A fire on an armed, edge-type channel (`chLevel`=0, message route off) clears its status bit. Its line is high for exactly one cycle.
- R4: A fire on a channel whose `chEnable` or `globalEn` is 0 acts as a clear. The status bit goes to 0, the line goes low, and no pulse and no message follow.
- R5: A channel with `chMsgEn`=1 never drives a line. An armed fire on it raises `msgValid` for one cycle and presents that channel's address and data words. When several such channels fire in the same cycle, the lowest index wins.
- R6: In the first cycle that `chMsgEn` of a channel is 1 after being 0, that channel is cleared. This applies even if it fires in the same cycle.
- R7: Once `legacyMode` is 1, `tickEnable` reads 0 one cycle later. Lines 0 and 8 then stop carrying the tick and real-time clock inputs.
- R8: Once `legacyMode` returns to 0, `tickEnable` reads 1 one cycle later. From that cycle, line 8 shows the captured real-time clock level and line 0 shows the captured tick level.
- R9: When `legacyMode` is 0, `tickIn` appears on line 0 and `rtcIn` on line 8 two cycles later (capture register, then line register). The real-time clock is captured in both modes.
- R10: During and after reset: `tickEnable` is 1, all status bits and lines are 0, `msgValid` is 0, and both captured input levels are 0.
- R11: When several sources share a line (level holds, edge pulses and pass-through), the line is their OR.
- R12: A clear event wins over a fire on the same channel in the same cycle. Every channel event shows on the status bits, the lines and the message outputs one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| globalEn | input | 1 | Global interrupt enable of the timer |
| legacyMode | input | 1 | Legacy replacement routing on |
| chEnable | input | NUM_CH | Per-channel interrupt enable |
| chLevel | input | NUM_CH | 1 = level signalling, 0 = edge |
| chMsgEn | input | NUM_CH | Per-channel message route enable |
| chRoute | input | NUM_CH*ROUTE_W | Per-channel output line select |
| msgAddr | input | NUM_CH*MSG_W | Per-channel message address words |
| msgData | input | NUM_CH*MSG_W | Per-channel message data words |
| fireEvt | input | NUM_CH | Channel fire events, one cycle each |
| clearEvt | input | NUM_CH | Channel clear events, one cycle each |
| tickIn | input | 1 | External tick timer interrupt input |
| rtcIn | input | 1 | External real-time clock interrupt input |
| irqLines | output | NUM_LINES | Interrupt output lines |
| chStatus | output | NUM_CH | Per-channel status bits |
| tickEnable | output | 1 | Enable for the external tick timer |
| msgValid | output | 1 | Message request, one cycle |
| msgAddrOut | output | MSG_W | Address of the message request |
| msgDataOut | output | MSG_W | Data of the message request |

## Verification
The bench targets these cases:
- Turning legacy mode off while the real-time clock input is high. A design that restored line 8 from the live input, or left it low, would show the wrong level in that cycle.
- A level channel and an edge channel that share one line, and a clear that arrives while the pulse is still out. Replacing the OR with a last-writer choice would drop either the held level or the pulse.
- A message enable that turns on while a level status bit is set, and message fires from two channels at once. These expose a missing forced clear, a line driven in message mode, and the wrong arbitration order.
- Fires on disabled channels, and a fire together with a clear. A design that latched the disabled fire or let the fire win would keep the line high.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Output lines taken over by channels 0 and 1 in legacy mode
  localparam int LEGACY_LINE_CH0 = 0;
  localparam int LEGACY_LINE_CH1 = 8;

  // Per-channel decision handed from control to datapath; at most one bit set
  typedef struct packed {
    logic setLvl;
    logic clrLvl;
    logic pulse;
    logic msgReq;
  } chStrobe_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    globalEn,
  input  logic [NUM_CH-1:0]       chEnable,
  input  logic [NUM_CH-1:0]       chLevel,
  input  logic [NUM_CH-1:0]       chMsgEn,
  input  logic [NUM_CH-1:0]       fireEvt,
  input  logic [NUM_CH-1:0]       clearEvt,
  output chStrobe_t [NUM_CH-1:0]  strb
);

  logic [NUM_CH-1:0] msgEnPrev;
  logic [NUM_CH-1:0] msgRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msgEnPrev <= '0;
    else        msgEnPrev <= chMsgEn;
  end

  assign msgRise = chMsgEn & ~msgEnPrev;

  // One decision per channel: clear sources first, then the fire type
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strb[i] = '0;
      if (msgRise[i] || clearEvt[i]) begin
        strb[i].clrLvl = 1'b1;
      end else if (fireEvt[i]) begin
        if (!(chEnable[i] && globalEn)) strb[i].clrLvl = 1'b1;
        else if (chMsgEn[i])            strb[i].msgReq = 1'b1;
        else if (chLevel[i])            strb[i].setLvl = 1'b1;
        else                            strb[i].pulse  = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R4: a fire on a disarmed channel becomes a clear
    p_fire_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fireEvt[g] && !(chEnable[g] && globalEn) |-> strb[g].clrLvl);
    // R5: message routing never reaches the pin actions
    p_msg_no_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chMsgEn[g] |-> !strb[g].pulse && !strb[g].setLvl);
    // R6: message route switching on forces a clear
    p_msg_rise_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chMsgEn[g]) |-> strb[g].clrLvl);
    // R12: clear takes priority over fire
    p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clearEvt[g] |-> strb[g].clrLvl && !strb[g].setLvl);
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 16,
  parameter int ROUTE_W   = 4,
  parameter int MSG_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      legacyMode,
  input  logic [NUM_CH-1:0]         chMsgEn,
  input  logic [NUM_CH*ROUTE_W-1:0] chRoute,
  input  logic [NUM_CH*MSG_W-1:0]   msgAddr,
  input  logic [NUM_CH*MSG_W-1:0]   msgData,
  input  logic                      tickIn,
  input  logic                      rtcIn,
  input  chStrobe_t [NUM_CH-1:0]    strb,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic [NUM_CH-1:0]         chStatus,
  output logic                      tickEnable,
  output logic                      msgValid,
  output logic [MSG_W-1:0]          msgAddrOut,
  output logic [MSG_W-1:0]          msgDataOut
);

  logic [NUM_CH-1:0]    statusNext;
  logic [NUM_CH-1:0]    chDrive;
  logic [ROUTE_W-1:0]   chDest [NUM_CH];
  logic [NUM_LINES-1:0] lineNext;
  logic                 tickCap;
  logic                 rtcCap;
  logic                 msgHit;
  logic [MSG_W-1:0]     msgAddrSel;
  logic [MSG_W-1:0]     msgDataSel;

  // Status update and per-channel pin drive
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (strb[i].setLvl)                     statusNext[i] = 1'b1;
      else if (strb[i].clrLvl || strb[i].pulse) statusNext[i] = 1'b0;
      else                                    statusNext[i] = chStatus[i];
      chDrive[i] = (statusNext[i] & ~chMsgEn[i]) | strb[i].pulse;
    end
  end

  // Destination line per channel; channels 0 and 1 follow legacy mode
  for (genvar g = 0; g < NUM_CH; g++) begin : g_dest
    if (g == 0) begin : g_l0
      assign chDest[g] = legacyMode ? ROUTE_W'(LEGACY_LINE_CH0) : chRoute[g*ROUTE_W +: ROUTE_W];
    end else if (g == 1) begin : g_l1
      assign chDest[g] = legacyMode ? ROUTE_W'(LEGACY_LINE_CH1) : chRoute[g*ROUTE_W +: ROUTE_W];
    end else begin : g_rt
      assign chDest[g] = chRoute[g*ROUTE_W +: ROUTE_W];
    end
  end

  // Each line is the OR of every source that lands on it
  always_comb begin
    for (int ln = 0; ln < NUM_LINES; ln++) begin
      lineNext[ln] = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (chDest[c] == ROUTE_W'(ln)) lineNext[ln] = lineNext[ln] | chDrive[c];
      end
    end
    lineNext[LEGACY_LINE_CH0] = lineNext[LEGACY_LINE_CH0] | (~legacyMode & tickCap);
    lineNext[LEGACY_LINE_CH1] = lineNext[LEGACY_LINE_CH1] | (~legacyMode & rtcCap);
  end

  // Lowest-index message request wins
  always_comb begin
    msgHit     = 1'b0;
    msgAddrSel = '0;
    msgDataSel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (strb[i].msgReq) begin
        msgHit     = 1'b1;
        msgAddrSel = msgAddr[i*MSG_W +: MSG_W];
        msgDataSel = msgData[i*MSG_W +: MSG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chStatus   <= '0;
      irqLines   <= '0;
      tickCap    <= 1'b0;
      rtcCap     <= 1'b0;
      tickEnable <= 1'b1;
      msgValid   <= 1'b0;
      msgAddrOut <= '0;
      msgDataOut <= '0;
    end else begin
      chStatus   <= statusNext;
      irqLines   <= lineNext;
      tickCap    <= tickIn;
      rtcCap     <= rtcIn;
      tickEnable <= ~legacyMode;
      msgValid   <= msgHit;
      if (msgHit) begin
        msgAddrOut <= msgAddrSel;
        msgDataOut <= msgDataSel;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R2: control hands over at most one action per channel
    p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strb[g].setLvl, strb[g].clrLvl, strb[g].pulse, strb[g].msgReq}));
    // R2: a held status bit survives until something clears it
    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chStatus[g] && !strb[g].clrLvl && !strb[g].pulse |=> chStatus[g]);
    // R3: an edge fire leaves the status bit clear
    p_edge_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      strb[g].pulse |=> !chStatus[g]);
  end

  // R1: legacy level fire of channel 0 shows on line 0
  p_legacy_ch0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    legacyMode && strb[0].setLvl |=> irqLines[LEGACY_LINE_CH0]);
  // R7: entering legacy mode drops the tick enable
  p_enter_legacy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(legacyMode) |=> !tickEnable);
  // R8: leaving legacy mode raises the tick enable
  p_leave_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(legacyMode) |=> tickEnable);

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 16,
  parameter int MSG_W     = 32,
  localparam int ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      globalEn,
  input  logic                      legacyMode,
  input  logic [NUM_CH-1:0]         chEnable,
  input  logic [NUM_CH-1:0]         chLevel,
  input  logic [NUM_CH-1:0]         chMsgEn,
  input  logic [NUM_CH*ROUTE_W-1:0] chRoute,
  input  logic [NUM_CH*MSG_W-1:0]   msgAddr,
  input  logic [NUM_CH*MSG_W-1:0]   msgData,
  input  logic [NUM_CH-1:0]         fireEvt,
  input  logic [NUM_CH-1:0]         clearEvt,
  input  logic                      tickIn,
  input  logic                      rtcIn,
  output logic [NUM_LINES-1:0]      irqLines,
  output logic [NUM_CH-1:0]         chStatus,
  output logic                      tickEnable,
  output logic                      msgValid,
  output logic [MSG_W-1:0]          msgAddrOut,
  output logic [MSG_W-1:0]          msgDataOut
);

  chStrobe_t [NUM_CH-1:0] strb;

  irq_router_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .globalEn (globalEn),
    .chEnable (chEnable),
    .chLevel  (chLevel),
    .chMsgEn  (chMsgEn),
    .fireEvt  (fireEvt),
    .clearEvt (clearEvt),
    .strb     (strb)
  );

  irq_router_dp #(
    .NUM_CH    (NUM_CH),
    .NUM_LINES (NUM_LINES),
    .ROUTE_W   (ROUTE_W),
    .MSG_W     (MSG_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .legacyMode (legacyMode),
    .chMsgEn    (chMsgEn),
    .chRoute    (chRoute),
    .msgAddr    (msgAddr),
    .msgData    (msgData),
    .tickIn     (tickIn),
    .rtcIn      (rtcIn),
    .strb       (strb),
    .irqLines   (irqLines),
    .chStatus   (chStatus),
    .tickEnable (tickEnable),
    .msgValid   (msgValid),
    .msgAddrOut (msgAddrOut),
    .msgDataOut (msgDataOut)
  );

endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NC = 4;
  localparam int NL = 16;
  localparam int RW = 4;
  localparam int MW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic globalEn = 1'b0;
  logic legacyMode = 1'b0;
  logic [NC-1:0] chEnable = '0;
  logic [NC-1:0] chLevel = '0;
  logic [NC-1:0] chMsgEn = '0;
  logic [NC-1:0] fireEvt = '0;
  logic [NC-1:0] clearEvt = '0;
  logic [NC*RW-1:0] chRoute = '0;
  logic [NC*MW-1:0] msgAddr;
  logic [NC*MW-1:0] msgData;
  logic tickIn = 1'b0;
  logic rtcIn = 1'b0;

  logic [NL-1:0] irqLines;
  logic [NC-1:0] chStatus;
  logic          tickEnable;
  logic          msgValid;
  logic [MW-1:0] msgAddrOut;
  logic [MW-1:0] msgDataOut;

  always #4 clk = ~clk;

  irq_router #(.NUM_CH(NC), .NUM_LINES(NL), .MSG_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .legacyMode(legacyMode),
    .chEnable(chEnable), .chLevel(chLevel), .chMsgEn(chMsgEn), .chRoute(chRoute),
    .msgAddr(msgAddr), .msgData(msgData), .fireEvt(fireEvt), .clearEvt(clearEvt),
    .tickIn(tickIn), .rtcIn(rtcIn), .irqLines(irqLines), .chStatus(chStatus),
    .tickEnable(tickEnable), .msgValid(msgValid), .msgAddrOut(msgAddrOut),
    .msgDataOut(msgDataOut)
  );

  // Behavioural reference model
  bit mStatus [NC];
  bit mPulse [NC];
  bit mPrevMsg [NC];
  logic [NL-1:0] mLines = '0;
  bit mTick = 0;
  bit mRtc = 0;
  bit mTickEn = 1;
  bit mMsgV = 0;
  logic [MW-1:0] mA = '0;
  logic [MW-1:0] mD = '0;
  int firstMsg;
  int dest;
  bit armed;
  bit rise;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        mStatus[c] = 0; mPulse[c] = 0; mPrevMsg[c] = 0;
      end
      mLines = '0; mTick = 0; mRtc = 0; mTickEn = 1; mMsgV = 0; mA = '0; mD = '0;
    end else begin
      firstMsg = -1;
      for (int c = 0; c < NC; c++) begin
        armed = chEnable[c] && globalEn;
        rise = chMsgEn[c] && !mPrevMsg[c];
        mPulse[c] = 0;
        if (rise || clearEvt[c]) mStatus[c] = 0;
        else if (fireEvt[c]) begin
          if (!armed) mStatus[c] = 0;
          else if (chMsgEn[c]) begin
            if (firstMsg < 0) firstMsg = c;
          end
          else if (chLevel[c]) mStatus[c] = 1;
          else begin
            mStatus[c] = 0; mPulse[c] = 1;
          end
        end
        mPrevMsg[c] = chMsgEn[c];
      end
      mLines = '0;
      for (int c = 0; c < NC; c++) begin
        dest = int'(chRoute[c*RW +: RW]);
        if (legacyMode && c == 0) dest = 0;
        if (legacyMode && c == 1) dest = 8;
        if ((mStatus[c] && !chMsgEn[c]) || mPulse[c]) mLines[dest] = 1'b1;
      end
      if (!legacyMode) begin
        if (mTick) mLines[0] = 1'b1;
        if (mRtc)  mLines[8] = 1'b1;
      end
      mTick = tickIn;
      mRtc = rtcIn;
      mTickEn = !legacyMode;
      mMsgV = (firstMsg >= 0);
      if (firstMsg >= 0) begin
        mA = msgAddr[firstMsg*MW +: MW];
        mD = msgData[firstMsg*MW +: MW];
      end
    end
  end

  int testsRun = 0;
  int testsFailed = 0;
  string curReq = "R10";

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [NC-1:0] expStatus;
    for (int c = 0; c < NC; c++) expStatus[c] = mStatus[c];
    check(irqLines === mLines, "irqLines", 64'(irqLines), 64'(mLines));
    check(chStatus === expStatus, "chStatus", 64'(chStatus), 64'(expStatus));
    check(tickEnable === mTickEn, "tickEnable", 64'(tickEnable), 64'(mTickEn));
    check(msgValid === mMsgV, "msgValid", 64'(msgValid), 64'(mMsgV));
    if (mMsgV) begin
      check(msgAddrOut === mA, "msgAddrOut", 64'(msgAddrOut), 64'(mA));
      check(msgDataOut === mD, "msgDataOut", 64'(msgDataOut), 64'(mD));
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic fire(input logic [NC-1:0] m);
    fireEvt = m; step(1); fireEvt = '0;
  endtask

  task automatic clr(input logic [NC-1:0] m);
    clearEvt = m; step(1); clearEvt = '0;
  endtask

  task automatic setRoute(input int c, input int v);
    chRoute[c*RW +: RW] = RW'(v);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog run did not complete");
    finishRun();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      msgAddr[c*MW +: MW] = 32'hA000_0000 + 32'(c);
      msgData[c*MW +: MW] = 32'hD000_0000 + 32'(c * 16);
    end
    // R10: reset values
    curReq = "R10";
    step(3);
    rst_n = 1'b1;
    step(2);
    globalEn = 1'b1; chEnable = '1;

    // R9: pass-through outside legacy mode, two-cycle latency
    curReq = "R9";
    tickIn = 1'b1; step(3);
    rtcIn = 1'b1; step(3);
    tickIn = 1'b0; step(2);
    rtcIn = 1'b0; step(3);

    // R2: level channel holds line 5 until cleared
    curReq = "R2";
    chLevel[2] = 1'b1; setRoute(2, 5); step(1);
    fire(4'b0100); step(5);
    clr(4'b0100); step(2);

    // R3: edge channel gives a single pulse
    curReq = "R3";
    setRoute(3, 6); step(1);
    fire(4'b1000); step(3);

    // R11: shared line, level hold plus edge pulse plus a clear during the pulse
    curReq = "R11";
    setRoute(3, 5); step(1);
    fire(4'b0100); step(2);
    fire(4'b1000); step(1);
    fireEvt = 4'b1000; clearEvt = 4'b0100; step(1); fireEvt = '0; clearEvt = '0;
    step(2);
    setRoute(2, 8); tickIn = 1'b1; rtcIn = 1'b1; step(2);
    fire(4'b0100); step(2); clr(4'b0100); step(1);
    rtcIn = 1'b0; tickIn = 1'b0; step(3);

    // R1: legacy routing of channels 0 and 1
    curReq = "R1";
    setRoute(0, 3); setRoute(1, 3); chLevel[0] = 1'b1; chLevel[1] = 1'b0;
    legacyMode = 1'b1; step(2);
    fire(4'b0001); step(2);
    fire(4'b0010); step(2);
    clr(4'b0001); step(1);
    legacyMode = 1'b0; step(1);
    fire(4'b0001); step(2);
    fire(4'b0010); step(2);
    clr(4'b0001); step(1);

    // R7: entering legacy mode with both inputs high
    curReq = "R7";
    tickIn = 1'b1; rtcIn = 1'b1; step(3);
    legacyMode = 1'b1; step(4);

    // R8: leaving legacy mode restores the captured clock level
    curReq = "R8";
    tickIn = 1'b0; step(2);
    rtcIn = 1'b0; step(1);
    rtcIn = 1'b1; step(1);
    legacyMode = 1'b0; step(4);
    rtcIn = 1'b0; step(3);

    // R4: fires on disarmed channels act as clears
    curReq = "R4";
    chLevel[2] = 1'b1; setRoute(2, 7); step(1);
    fire(4'b0100); step(1);
    globalEn = 1'b0; fire(4'b0100); step(2);
    globalEn = 1'b1; fire(4'b0100); step(1);
    chEnable[2] = 1'b0; fire(4'b0100); step(2);
    chEnable[2] = 1'b1; chEnable[3] = 1'b0; fire(4'b1000); step(2);
    chEnable[3] = 1'b1; fire(4'b0100); step(1);

    // R5: message route, no pin, lowest index wins
    curReq = "R5";
    chMsgEn = 4'b0110; step(2);
    fire(4'b0110); step(2);
    fire(4'b0100); step(2);
    fire(4'b1110); step(2);
    chMsgEn = '0; step(2);

    // R6: message enable turning on clears the channel
    curReq = "R6";
    chLevel[0] = 1'b1; setRoute(0, 4); fire(4'b0001); step(1);
    chMsgEn[0] = 1'b1; step(2);
    chMsgEn[0] = 1'b0; fire(4'b0001); step(1);
    chMsgEn[0] = 1'b1; fireEvt = 4'b0001; step(1); fireEvt = '0;
    step(1); chMsgEn = '0; step(1);

    // R12: clear wins over a simultaneous fire
    curReq = "R12";
    fire(4'b0001); step(1);
    fireEvt = 4'b1001; clearEvt = 4'b1001; step(1); fireEvt = '0; clearEvt = '0;
    step(2);

    finishRun();
  end

endmodule